// File: doc/BRIEF.md
# Timer Status and Interrupt Flag Register

This block holds the event flags and interrupt enables for one channel of a 16-bit up/down timer. The counter core supplies a count-direction level, an underflow pulse with a phase-counting-mode qualifier, and two compare/capture match pulses (A and B). Each event sets a sticky flag. The flag stays set until software reads it as one and then writes a zero to it. Flags A and B each drive an interrupt request line through their own enable bit.

Software reaches the block over a single-cycle register bus with two locations: status at address 0 and interrupt enable at address 1. Read data is combinational. The parameter `RESTRICTED_CH` selects a reduced channel. In that variant the direction and underflow positions are reserved and read as zero.

Top module: `tmr_stat_irq`

## Requirements
- R1: After reset all flags and both enable bits are 0 and both interrupt lines are low.
- R2: Status bit 7 reads the direction input (1 = counting up, 0 = counting down). Status bit 6 always reads 1. Writes change neither bit.
- R3: A match A pulse sets status bit 0 and a match B pulse sets status bit 1, one clock later. Both flags stay set after the pulse ends.
- R4: An underflow pulse sets status bit 5 only while the phase-counting-mode input is high.
- R5: A status write clears a flag only when the data bit for that flag is 0 and the last status access was a read that returned 1 for that flag. A write of 0 without that prior read leaves the flag set.
- R6: Writing 1 to a flag leaves it unchanged. Every status write uses up the read-as-one arming, so a later zero write without a fresh read does not clear the flag.
- R7: If a set event and a qualifying clear write fall in the same cycle, the flag stays 1.
- R8: Enable bit 0 (for A) and enable bit 1 (for B) sit at address 1. They can be read and written, and they reset to 0. Bits 7..2 there read 0.
- R9: irq_a_o is high exactly while flag A and enable bit 0 are both 1. irq_b_o is high exactly while flag B and enable bit 1 are both 1.
- R10: With RESTRICTED_CH=1, status bits 7 and 5 always read 0 and the underflow input has no effect.
- R11: While rd_en_i is low, rdata_o is 0. Status bits 4..2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_up_i | input | 1 | Count direction from the counter core (1 = up) |
| udf_i | input | 1 | Underflow pulse (0x0000 to 0xFFFF wrap) |
| phase_mode_i | input | 1 | Phase counting mode active |
| match_a_i | input | 1 | Compare/capture match A pulse |
| match_b_i | input | 1 | Compare/capture match B pulse |
| addr_i | input | ADDR_W | Register select: 0 = status, 1 = enable |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe, also arms the clearing of flags read as 1 |
| wdata_i | input | REG_W | Write data |
| rdata_o | output | REG_W | Combinational read data |
| irq_a_o | output | 1 | Interrupt request A |
| irq_b_o | output | 1 | Interrupt request B |

## Verification
A set pulse or a bus write that is accepted at a clock edge shows up in the flags, in the enables, and therefore in both interrupt lines right after that same edge. Read data follows the current register state combinationally, in the cycle the strobe is high. The bench drives every input just after a rising edge and samples at the following falling edge, so each result is observed exactly one register stage after the stimulus that caused it. The scoreboard queues each expected read value before the strobe is raised. The monitor pops that value at the falling edge inside the strobe cycle, which also proves that a read only arms a clear from the next edge onward.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned BIT_MA  = 0;
  localparam int unsigned BIT_MB  = 1;
  localparam int unsigned BIT_UF  = 5;
  localparam int unsigned BIT_RSV = 6;
  localparam int unsigned BIT_DIR = 7;
  localparam int unsigned N_FLAGS = 3;  // index 0 = A, 1 = B, 2 = underflow
  localparam int unsigned FI_UF   = 2;
endpackage

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_stat_i,
  input  logic wr_stat_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      // set has priority over a qualifying clear
      if (set_i)                                 flag_q <= 1'b1;
      else if (wr_stat_i && arm_q && !wbit_i)    flag_q <= 1'b0;
      // any status write consumes the arming; read arms only if it saw a 1
      if (wr_stat_i)                             arm_q <= 1'b0;
      else if (rd_stat_i && flag_q)              arm_q <= 1'b1;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = arm_q;
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
  import tmr_stat_pkg::*;
#(
  parameter bit RESTRICTED_CH = 1'b0
) (
  input  logic               rd_en_i,
  input  logic               sel_ien_i,
  input  logic               dir_up_i,
  input  logic [N_FLAGS-1:0] flags_i,
  input  logic [1:0]         ien_i,
  output logic [REG_W-1:0]   rdata_o
);
  logic [REG_W-1:0] stat_w, ien_w;

  always_comb begin
    stat_w          = '0;
    stat_w[BIT_MA]  = flags_i[0];
    stat_w[BIT_MB]  = flags_i[1];
    stat_w[BIT_RSV] = 1'b1;
    if (!RESTRICTED_CH) begin
      stat_w[BIT_UF]  = flags_i[FI_UF];
      stat_w[BIT_DIR] = dir_up_i;
    end
    ien_w      = '0;
    ien_w[1:0] = ien_i;
  end

  assign rdata_o = !rd_en_i ? '0 : (sel_ien_i ? ien_w : stat_w);
endmodule

// File: rtl/tmr_stat_irq.sv
module tmr_stat_irq
  import tmr_stat_pkg::*;
#(
  parameter bit          RESTRICTED_CH = 1'b0,
  parameter int unsigned ADDR_W        = 1,
  parameter int unsigned STAT_ADDR     = 0,
  parameter int unsigned IEN_ADDR      = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_up_i,
  input  logic              udf_i,
  input  logic              phase_mode_i,
  input  logic              match_a_i,
  input  logic              match_b_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_a_o,
  output logic              irq_b_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_ADDR);

  logic sel_stat, sel_ien, rd_stat, wr_stat, wr_ien;
  logic [N_FLAGS-1:0] flag_q, arm_q;
  logic [1:0] match_v, ien_q;

  assign sel_stat = (addr_i == A_STAT);
  assign sel_ien  = (addr_i == A_IEN);
  assign rd_stat  = rd_en_i && sel_stat;
  assign wr_stat  = wr_en_i && sel_stat;
  assign wr_ien   = wr_en_i && sel_ien;
  assign match_v  = {match_b_i, match_a_i};

  for (genvar g = 0; g < 2; g++) begin : g_match
    localparam int unsigned POS = (g == 0) ? BIT_MA : BIT_MB;
    tmr_flag_cell i_cell (
      .clk_i, .rst_ni,
      .set_i    (match_v[g]),
      .rd_stat_i(rd_stat),
      .wr_stat_i(wr_stat),
      .wbit_i   (wdata_i[POS]),
      .flag_o   (flag_q[g]),
      .armed_o  (arm_q[g])
    );
  end

  if (!RESTRICTED_CH) begin : g_uf
    tmr_flag_cell i_cell (
      .clk_i, .rst_ni,
      .set_i    (udf_i && phase_mode_i),
      .rd_stat_i(rd_stat),
      .wr_stat_i(wr_stat),
      .wbit_i   (wdata_i[BIT_UF]),
      .flag_o   (flag_q[FI_UF]),
      .armed_o  (arm_q[FI_UF])
    );
  end else begin : g_no_uf
    assign flag_q[FI_UF] = 1'b0;
    assign arm_q[FI_UF]  = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= '0;
    else if (wr_ien) ien_q <= wdata_i[1:0];
  end

  tmr_rd_mux #(.RESTRICTED_CH(RESTRICTED_CH)) i_rd_mux (
    .rd_en_i,
    .sel_ien_i(sel_ien),
    .dir_up_i,
    .flags_i  (flag_q),
    .ien_i    (ien_q),
    .rdata_o
  );

  assign irq_a_o = flag_q[0] && ien_q[0];
  assign irq_b_o = flag_q[1] && ien_q[1];

  logic unused_in;
  assign unused_in = ^{wdata_i, udf_i, phase_mode_i, arm_q};
endmodule

// File: rtl/tmr_stat_irq_chk.sv
module tmr_stat_irq_chk
  import tmr_stat_pkg::*;
#(
  parameter bit          RESTRICTED_CH = 1'b0,
  parameter int unsigned ADDR_W        = 1,
  parameter int unsigned STAT_ADDR     = 0,
  parameter int unsigned IEN_ADDR      = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               udf_i,
  input logic               phase_mode_i,
  input logic               match_a_i,
  input logic               match_b_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [REG_W-1:0]   wdata_i,
  input logic [REG_W-1:0]   rdata_o,
  input logic               irq_a_o,
  input logic [N_FLAGS-1:0] flag_q,
  input logic [N_FLAGS-1:0] arm_q
);
  logic wr_st, rd_st;
  assign wr_st = wr_en_i && (addr_i == ADDR_W'(STAT_ADDR));
  assign rd_st = rd_en_i && (addr_i == ADDR_W'(STAT_ADDR));

  assert_set_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_a_i |=> flag_q[0]);
  assert_set_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_b_i |=> flag_q[1]);
  assert_uf_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q[FI_UF] && !(udf_i && phase_mode_i)) |=> !flag_q[FI_UF]);
  assert_noarm_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st && !arm_q[0] && flag_q[0]) |=> flag_q[0]);
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st && arm_q[0] && !wdata_i[BIT_MA] && !match_a_i) |=> !flag_q[0]);
  assert_wr1_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st && wdata_i[BIT_MB] && flag_q[1]) |=> flag_q[1]);
  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st && arm_q[1] && match_b_i) |=> flag_q[1]);
  assert_ien_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(IEN_ADDR) && !wdata_i[0]) |=> !irq_a_o);
  assert_rsv_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st |-> rdata_o[BIT_RSV]);
  assert_restricted_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RESTRICTED_CH && rd_st) |-> (!rdata_o[BIT_DIR] && !rdata_o[BIT_UF]));
  assert_idle_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0));
endmodule

bind tmr_stat_irq tmr_stat_irq_chk #(
  .RESTRICTED_CH(RESTRICTED_CH), .ADDR_W(ADDR_W),
  .STAT_ADDR(STAT_ADDR), .IEN_ADDR(IEN_ADDR)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .udf_i(udf_i), .phase_mode_i(phase_mode_i),
  .match_a_i(match_a_i), .match_b_i(match_b_i), .addr_i(addr_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .irq_a_o(irq_a_o), .flag_q(flag_q), .arm_q(arm_q)
);

// File: tb/test_tmr_stat_irq.sv
`timescale 1ns/1ps
module test_tmr_stat_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_up = 1'b1, udf = 1'b0, pmode = 1'b0, ma = 1'b0, mb = 1'b0;
  logic addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, rdata_rs;
  logic irq_a, irq_b, irq_a_rs, irq_b_rs;
  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {logic [7:0] exp; logic [7:0] exp_rs; bit chk_rs; string req;} item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;  // 250 MHz

  tmr_stat_irq i_tmr_stat_irq (
    .clk_i(clk), .rst_ni(rst_n), .dir_up_i(dir_up), .udf_i(udf),
    .phase_mode_i(pmode), .match_a_i(ma), .match_b_i(mb), .addr_i(addr),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata),
    .irq_a_o(irq_a), .irq_b_o(irq_b));

  tmr_stat_irq #(.RESTRICTED_CH(1'b1)) i_tmr_stat_irq_rs (
    .clk_i(clk), .rst_ni(rst_n), .dir_up_i(dir_up), .udf_i(udf),
    .phase_mode_i(pmode), .match_a_i(ma), .match_b_i(mb), .addr_i(addr),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata_rs),
    .irq_a_o(irq_a_rs), .irq_b_o(irq_b_rs));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per read cycle
  always @(negedge clk) begin
    if (rd_en && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.req, rdata, it.exp);
      if (it.chk_rs) check({it.req, "/R10"}, rdata_rs, it.exp_rs);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic a, input logic [7:0] e, input logic [7:0] ers,
                    input bit crs, input string req);
    item_t it;
    it.exp = e; it.exp_rs = ers; it.chk_rs = crs; it.req = req;
    sb_q.push_back(it);
    addr = a; rd_en = 1'b1;
    step();
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic pa, input logic pb, input logic pu);
    ma = pa; mb = pb; udf = pu;
    step();
    ma = 1'b0; mb = 1'b0; udf = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 / R2 reset state
    check("R1 irq_a", {7'b0, irq_a}, 8'h00);
    check("R1 irq_b", {7'b0, irq_b}, 8'h00);
    rd(1'b0, 8'hC0, 8'h40, 1, "R1 R2 status after reset");
    rd(1'b1, 8'h00, 8'h00, 1, "R8 enable after reset");
    dir_up = 1'b0;
    rd(1'b0, 8'h40, 8'h40, 1, "R2 direction down");
    // R2/R6: write all ones with no flags set
    wr(1'b0, 8'hFF);
    rd(1'b0, 8'h40, 8'h40, 1, "R2 reserved ignore write");
    dir_up = 1'b1;
    // R3 set A, R5 read-then-clear
    pulse(1, 0, 0);
    step();
    rd(1'b0, 8'hC1, 8'h41, 1, "R3 match A sticky");
    wr(1'b0, 8'h00);
    rd(1'b0, 8'hC0, 8'h40, 1, "R5 cleared after read");
    // R5 zero write without read keeps flag
    pulse(0, 1, 0);
    wr(1'b0, 8'h00);
    rd(1'b0, 8'hC2, 8'h42, 1, "R5 no clear without read");
    // R6 write of 1 consumes arming
    wr(1'b0, 8'hFF);
    wr(1'b0, 8'h00);
    rd(1'b0, 8'hC2, 8'h42, 1, "R6 write one consumes arm");
    wr(1'b0, 8'h00);
    rd(1'b0, 8'hC0, 8'h40, 1, "R5 clear B");
    // R4 underflow gating
    pmode = 1'b0;
    pulse(0, 0, 1);
    rd(1'b0, 8'hC0, 8'h40, 1, "R4 underflow outside mode");
    pmode = 1'b1;
    pulse(0, 0, 1);
    rd(1'b0, 8'hE0, 8'h40, 1, "R4 underflow in mode");
    wr(1'b0, 8'h00);
    rd(1'b0, 8'hC0, 8'h40, 1, "R5 clear underflow");
    pmode = 1'b0;
    // R7 set wins over clear
    pulse(1, 0, 0);
    rd(1'b0, 8'hC1, 8'h41, 1, "R7 A set before race");
    ma = 1'b1;
    wr(1'b0, 8'h00);
    ma = 1'b0;
    rd(1'b0, 8'hC1, 8'h41, 1, "R7 set wins");
    wr(1'b0, 8'h00);
    rd(1'b0, 8'hC0, 8'h40, 1, "R7 clear after race");
    // R8 enables, R9 irq gating
    wr(1'b1, 8'hFF);
    rd(1'b1, 8'h03, 8'h03, 1, "R8 enable readback");
    check("R9 irq_a no flag", {7'b0, irq_a}, 8'h00);
    pulse(1, 0, 0);
    check("R9 irq_a on", {7'b0, irq_a}, 8'h01);
    check("R9 irq_b off", {7'b0, irq_b}, 8'h00);
    pulse(0, 1, 0);
    check("R9 irq_b on", {7'b0, irq_b}, 8'h01);
    wr(1'b1, 8'h01);
    check("R9 irq_b masked", {7'b0, irq_b}, 8'h00);
    check("R9 irq_a kept", {7'b0, irq_a}, 8'h01);
    rd(1'b0, 8'hC3, 8'h43, 1, "R9 both flags");
    wr(1'b0, 8'h00);
    check("R9 irq_a after clear", {7'b0, irq_a}, 8'h00);
    check("R10 restricted irq_a", {7'b0, irq_a_rs}, 8'h00);
    // R11 idle bus
    addr = 1'b0;
    #1;
    check("R11 idle rdata", rdata, 8'h00);
    check("R11 idle rdata restricted", rdata_rs, 8'h00);
    step();
    check("R3 scoreboard drained", 8'(sb_q.size()), 8'h00);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule